// File: doc/BRIEF.md
# Keyed Fractional Bit-Clock Divider

This block derives an audio bit clock from one of several source clocks. Each source is delivered as a one-cycle enable strobe in the system clock domain. Source slot 0 stands for a tied-off input. The selected strobes are counted by a divider whose ratio has a 12-bit integer part and a 12-bit fraction. With noise shaping on, a first-order accumulator mixes periods of DIVI and DIVI+1 strobes, so that the long-run ratio equals DIVI + DIVF/4096.

Two 32-bit registers are written over a plain write port: a control word and a divisor word. A write lands only if its top byte carries the key value 0x5A.

Stopping the divider is graceful. After enable is cleared, the busy flag holds until the running period ends. A separate kill bit halts and clears the generator at once. The block produces a one-cycle strobe per completed period and a half-duty clock level.

Top module: `fracdiv_clkgen`

## Requirements
- R1: A write whose wr_data_i[31:24] differs from 0x5A leaves both registers unchanged; wr_sel_i=0 addresses control and wr_sel_i=1 addresses the divisor.
- R2: Control word layout on read (rd_sel_i=0, combinational): source select [2:0], enable bit 4, kill bit 5, read-only busy bit 7, invert bit 8, shaping order [10:9]; all other bits read 0; everything reads 0 after reset.
- R3: Divisor word layout: fraction DIVF in [11:0], integer DIVI in [23:12]; reads back as written (rd_sel_i=1), upper byte 0.
- R4: With order 0 the fraction is ignored and every period spans exactly DIVI selected strobes. stb_o is high for one cycle, in the cycle after the strobe that closes a period, and never in a cycle not preceded by a selected strobe.
- R5: With a nonzero order, a 12-bit accumulator adds DIVF at each period boundary; its carry makes the next period DIVI+1 strobes, otherwise DIVI. The accumulator is zero when the generator starts.
- R6: Clearing enable does not stop the output at once: busy stays 1 until the running period completes, then falls in the same cycle as that period's stb_o.
- R7: While the stored kill bit is 1, the generator is cleared on the next clock: busy 0, no stb_o, clk_o at its idle level, regardless of busy state.
- R8: Source select 0 yields no strobes, so no period ever completes even while busy.
- R9: A divisor write while busy does not alter the running period; it takes effect from the next period boundary.
- R10: A DIVI of 0 or 1 divides by 2.
- R11: clk_o equals the invert bit while idle; while busy it is the invert bit XOR (position in period < period length/2).
- R12: The generator starts on the clock after the enable bit is stored with kill clear; busy reads 1 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 8 | One enable strobe per source slot; slot 0 is never used |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 divisor |
| wr_data_i | input | 32 | Write data, key byte in [31:24] |
| rd_sel_i | input | 1 | Read target: 0 control, 1 divisor |
| rd_data_o | output | 32 | Read data (combinational) |
| stb_o | output | 1 | One-cycle strobe per completed period |
| clk_o | output | 1 | Divided clock level |

## Verification
A written value sits in its register after one edge. The generator reacts to it on the following edge, so busy, a changed period length or a kill show two edges after the write cycle. stb_o rises one cycle after the closing source strobe, and busy falls in that same cycle when stopping. The bench runs a behavioural model that applies the register and generator updates in that order at each rising edge. It compares rd_data_o, stb_o and clk_o at every falling edge. Directed checks measure the cycle distance between successive stb_o pulses with one strobe per cycle, so a gap equals a period length.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
  localparam int SRC_W = 3;
  localparam int NSRC = 1 << SRC_W;
  localparam logic [7:0] KEY = 8'h5A;
  localparam int B_EN = 4;
  localparam int B_KILL = 5;
  localparam int B_BUSY = 7;
  localparam int B_INV = 8;
  localparam int B_ORD = 9;

  typedef struct packed {
    logic [1:0]       order;
    logic             inv;
    logic             kill;
    logic             en;
    logic [SRC_W-1:0] src;
  } ctrl_t;
endpackage

// File: rtl/fracdiv_regs.sv
module fracdiv_regs
  import fracdiv_pkg::*;
#(
  parameter int DIVI_W = 12,
  parameter int FRAC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_sel_i,
  input  logic              busy_i,
  output ctrl_t             ctrl_o,
  output logic [DIVI_W-1:0] divi_o,
  output logic [FRAC_W-1:0] divf_o,
  output logic [31:0]       rd_data_o
);
  ctrl_t             ctrl_q;
  logic [DIVI_W-1:0] divi_q;
  logic [FRAC_W-1:0] divf_q;
  logic              key_ok;

  assign key_ok = (wr_data_i[31:24] == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      divi_q <= '0;
      divf_q <= '0;
    end else if (wr_en_i && key_ok) begin
      if (!wr_sel_i) begin
        ctrl_q.src   <= wr_data_i[SRC_W-1:0];
        ctrl_q.en    <= wr_data_i[B_EN];
        ctrl_q.kill  <= wr_data_i[B_KILL];
        ctrl_q.inv   <= wr_data_i[B_INV];
        ctrl_q.order <= wr_data_i[B_ORD+1:B_ORD];
      end else begin
        divf_q <= wr_data_i[FRAC_W-1:0];
        divi_q <= wr_data_i[FRAC_W +: DIVI_W];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (!rd_sel_i) begin
      rd_data_o[SRC_W-1:0]       = ctrl_q.src;
      rd_data_o[B_EN]            = ctrl_q.en;
      rd_data_o[B_KILL]          = ctrl_q.kill;
      rd_data_o[B_BUSY]          = busy_i;
      rd_data_o[B_INV]           = ctrl_q.inv;
      rd_data_o[B_ORD+1:B_ORD]   = ctrl_q.order;
    end else begin
      rd_data_o[FRAC_W-1:0]      = divf_q;
      rd_data_o[FRAC_W +: DIVI_W] = divi_q;
    end
  end

  assign ctrl_o = ctrl_q;
  assign divi_o = divi_q;
  assign divf_o = divf_q;

  AST_KEY_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !key_ok |=> $stable(ctrl_q) && $stable(divi_q) && $stable(divf_q)); // R1
endmodule

// File: rtl/fracdiv_src_sel.sv
module fracdiv_src_sel
  import fracdiv_pkg::*;
(
  input  logic [NSRC-1:0]  src_tick_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             tick_o
);
  logic [NSRC-1:0] live;

  // slot 0 is the tied-off source
  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    if (g == 0) begin : g_gnd
      assign live[g] = 1'b0;
    end else begin : g_src
      assign live[g] = src_tick_i[g];
    end
  end

  assign tick_o = live[src_i];
endmodule

// File: rtl/fracdiv_core.sv
module fracdiv_core #(
  parameter int DIVI_W = 12,
  parameter int FRAC_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              kill_i,
  input  logic              inv_i,
  input  logic [1:0]        order_i,
  input  logic [DIVI_W-1:0] divi_i,
  input  logic [FRAC_W-1:0] divf_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              stb_o,
  output logic              clk_o
);
  localparam int LEN_W = DIVI_W + 1;

  logic              busy_q, stb_q;
  logic [LEN_W-1:0]  cnt_q, len_q, base_len;
  logic [FRAC_W-1:0] acc_q, frac_in;
  logic [FRAC_W:0]   sum;
  logic              last;

  assign base_len = (divi_i < DIVI_W'(2)) ? LEN_W'(2) : {1'b0, divi_i};
  assign frac_in  = (order_i != 2'd0) ? divf_i : '0;
  assign sum      = {1'b0, acc_q} + {1'b0, frac_in};
  assign last     = busy_q && tick_i && (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      cnt_q  <= '0;
      len_q  <= LEN_W'(2);
      acc_q  <= '0;
    end else if (kill_i) begin
      busy_q <= 1'b0;
      stb_q  <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else begin
      stb_q <= last;
      if (!busy_q) begin
        if (en_i) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          acc_q  <= '0;
          len_q  <= base_len;
        end
      end else if (tick_i) begin
        if (last) begin
          cnt_q <= '0;
          if (!en_i) begin
            busy_q <= 1'b0;
          end else begin
            // pending divisor lands only here
            acc_q <= sum[FRAC_W-1:0];
            len_q <= base_len + LEN_W'(sum[FRAC_W]);
          end
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign stb_o  = stb_q;
  assign clk_o  = inv_i ^ (busy_q && (cnt_q < (len_q >> 1)));

  AST_KILL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> !busy_q && !stb_q); // R7
  AST_STB_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !stb_q); // R4
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q < len_q); // R4
  AST_MIN_DIVIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> len_q >= LEN_W'(2)); // R10
  AST_STOP_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && $past(busy_q) && !$past(kill_i) |-> stb_q); // R6
endmodule

// File: rtl/fracdiv_clkgen.sv
module fracdiv_clkgen
  import fracdiv_pkg::*;
#(
  parameter int DIVI_W = 12,
  parameter int FRAC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_tick_i,
  input  logic            wr_en_i,
  input  logic            wr_sel_i,
  input  logic [31:0]     wr_data_i,
  input  logic            rd_sel_i,
  output logic [31:0]     rd_data_o,
  output logic            stb_o,
  output logic            clk_o
);
  ctrl_t             ctrl;
  logic [DIVI_W-1:0] divi;
  logic [FRAC_W-1:0] divf;
  logic              busy, tick;

  fracdiv_regs #(.DIVI_W(DIVI_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .busy_i(busy),
    .ctrl_o(ctrl), .divi_o(divi), .divf_o(divf), .rd_data_o(rd_data_o)
  );

  fracdiv_src_sel u_src (
    .src_tick_i(src_tick_i), .src_i(ctrl.src), .tick_o(tick)
  );

  fracdiv_core #(.DIVI_W(DIVI_W), .FRAC_W(FRAC_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(ctrl.en), .kill_i(ctrl.kill), .inv_i(ctrl.inv), .order_i(ctrl.order),
    .divi_i(divi), .divf_i(divf), .tick_i(tick),
    .busy_o(busy), .stb_o(stb_o), .clk_o(clk_o)
  );
endmodule

// File: tb/fracdiv_clkgen_bench.sv
module fracdiv_clkgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = 8'b0000_0011;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        stb, clko;

  int errors = 0, checks = 0, cyc = 0;
  int stb_times[$];
  int m_src, m_en, m_kill, m_inv, m_ord, m_divi, m_divf;
  int m_busy, m_cnt, m_len, m_acc, m_stb;
  int tk, lst, sum;
  bit done = 0;

  fracdiv_clkgen u_fracdiv_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data), .stb_o(stb), .clk_o(clko)
  );

  always #5 clk = ~clk;

  function automatic int eff(int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // behavioural model, updated on each rising edge from pre-edge state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_src = 0; m_en = 0; m_kill = 0; m_inv = 0; m_ord = 0; m_divi = 0; m_divf = 0;
      m_busy = 0; m_cnt = 0; m_len = 2; m_acc = 0; m_stb = 0;
    end else begin
      cyc++;
      tk  = (m_src != 0 && src_tick[m_src]) ? 1 : 0;
      lst = (m_busy != 0 && tk != 0 && m_cnt == m_len - 1) ? 1 : 0;
      if (m_kill != 0) begin
        m_busy = 0; m_cnt = 0; m_acc = 0; m_stb = 0;
      end else begin
        m_stb = lst;
        if (m_busy == 0) begin
          if (m_en != 0) begin m_busy = 1; m_cnt = 0; m_acc = 0; m_len = eff(m_divi); end
        end else if (tk != 0) begin
          if (lst != 0) begin
            m_cnt = 0;
            if (m_en == 0) m_busy = 0;
            else begin
              sum = m_acc + ((m_ord != 0) ? m_divf : 0);
              m_acc = sum % 4096;
              m_len = eff(m_divi) + sum / 4096;
            end
          end else m_cnt++;
        end
      end
      if (wr_en && wr_data[31:24] == 8'h5A) begin
        if (!wr_sel) begin
          m_src = int'(wr_data[2:0]); m_en = int'(wr_data[4]); m_kill = int'(wr_data[5]);
          m_inv = int'(wr_data[8]); m_ord = int'(wr_data[10:9]);
        end else begin
          m_divi = int'(wr_data[23:12]); m_divf = int'(wr_data[11:0]);
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int exp_rd, exp_clk;
    if (rst_n && !done) begin
      if (rd_sel) exp_rd = (m_divi << 12) | m_divf;
      else exp_rd = (m_ord << 9) | (m_inv << 8) | (m_busy << 7) | (m_kill << 5) | (m_en << 4) | m_src;
      exp_clk = m_inv ^ ((m_busy != 0 && m_cnt < m_len / 2) ? 1 : 0);
      chk(rd_data == 32'(exp_rd), "R2 model rd_data", int'(rd_data), exp_rd);
      chk(stb == (m_stb != 0), "R4 model stb_o", int'(stb), m_stb);
      chk(clko == (exp_clk != 0), "R11 model clk_o", int'(clko), exp_clk);
      if (stb) stb_times.push_back(cyc);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      src_tick[2] = (cyc % 3 == 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  task automatic wr(bit sel, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic next_stb(output int t);
    int n0;
    n0 = stb_times.size();
    while (stb_times.size() == n0) @(negedge clk);
    #1;
    t = stb_times[$];
  endtask

  task automatic gap(output int g);
    int a, b;
    next_stb(a);
    next_stb(b);
    g = b - a;
  endtask

  initial begin
    int g, t0, t1, t2, s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 32'h0, "R2 reset ctrl", int'(rd_data), 0);
    chk(!stb && !clko, "R2 reset outputs", int'({stb, clko}), 0);
    rd_sel = 1'b1; #1;
    chk(rd_data == 32'h0, "R3 reset div", int'(rd_data), 0);

    wr(1'b1, 32'h5A00_5123);
    @(negedge clk);
    chk(rd_data == 32'h0000_5123, "R3 div readback", int'(rd_data), 32'h5123);
    wr(1'b1, 32'h3300_9000);
    @(negedge clk);
    chk(rd_data == 32'h0000_5123, "R1 div bad key", int'(rd_data), 32'h5123);
    rd_sel = 1'b0;
    wr(1'b0, 32'hA500_0011);
    @(negedge clk);
    chk(rd_data == 32'h0, "R1 ctrl bad key", int'(rd_data), 0);

    // order 0: fraction 0x123 ignored
    wr(1'b0, 32'h5A00_0011);
    @(negedge clk);
    chk(rd_data[7] == 1'b0, "R12 busy one edge after store", int'(rd_data[7]), 0);
    @(negedge clk);
    chk(rd_data == 32'h91, "R12 busy and ctrl readback", int'(rd_data), 32'h91);
    gap(g); chk(g == 5, "R4 period order0", g, 5);
    gap(g); chk(g == 5, "R4 period order0 repeat", g, 5);

    // R9: divisor change mid period
    next_stb(t0);
    wr(1'b1, 32'h5A00_9000);
    next_stb(t1);
    next_stb(t2);
    chk(t1 - t0 == 5, "R9 running period unchanged", t1 - t0, 5);
    chk(t2 - t1 == 9, "R9 new period at boundary", t2 - t1, 9);

    // order 0 with half fraction
    wr(1'b1, 32'h5A00_3800);
    next_stb(t0); next_stb(t0);
    gap(g); chk(g == 3, "R4 fraction ignored", g, 3);

    // order 1
    wr(1'b0, 32'h5A00_0211);
    next_stb(t0); next_stb(t0);
    next_stb(t0);
    s = 0;
    for (int i = 0; i < 4; i++) begin
      next_stb(t1);
      chk((t1 - t0 == 3) || (t1 - t0 == 4), "R5 period is DIVI or DIVI+1", t1 - t0, 3);
      s += t1 - t0;
      t0 = t1;
    end
    chk(s == 14, "R5 average ratio 3.5", s, 14);

    // minimum divide
    wr(1'b0, 32'h5A00_0011);
    wr(1'b1, 32'h5A00_1000);
    next_stb(t0); next_stb(t0);
    gap(g); chk(g == 2, "R10 DIVI=1", g, 2);
    wr(1'b1, 32'h5A00_0000);
    next_stb(t0); next_stb(t0);
    gap(g); chk(g == 2, "R10 DIVI=0", g, 2);

    // graceful stop
    wr(1'b1, 32'h5A00_8000);
    next_stb(t0); next_stb(t0);
    wr(1'b0, 32'h5A00_0001);
    @(negedge clk);
    chk(rd_data[7] == 1'b1, "R6 busy held after enable cleared", int'(rd_data[7]), 1);
    next_stb(t1);
    chk(t1 - t0 == 8, "R6 final period completes", t1 - t0, 8);
    chk(rd_data[7] == 1'b0, "R6 busy falls with last strobe", int'(rd_data[7]), 0);

    // idle level with invert
    wr(1'b0, 32'h5A00_0101);
    @(negedge clk);
    chk(clko == 1'b1, "R11 idle level inverted", int'(clko), 1);

    // kill while running on slow source
    wr(1'b1, 32'h5A03_2000);
    wr(1'b0, 32'h5A00_0012);
    repeat (20) @(posedge clk);
    wr(1'b0, 32'h5A00_0032);
    @(posedge clk);
    @(negedge clk);
    chk(rd_data[7] == 1'b0 && !stb, "R7 kill clears generator", int'({rd_data[7], stb}), 0);
    chk(clko == 1'b0, "R7 output idle after kill", int'(clko), 0);
    repeat (10) @(negedge clk);
    chk(rd_data[7] == 1'b0, "R7 held while kill set", int'(rd_data[7]), 0);

    // ground source: slot 0 strobes every cycle yet nothing happens
    wr(1'b0, 32'h5A00_0010);
    s = stb_times.size();
    repeat (40) @(negedge clk);
    chk(stb_times.size() == s, "R8 no strobe from slot 0", stb_times.size() - s, 0);
    chk(rd_data[7] == 1'b1, "R8 busy with no source", int'(rd_data[7]), 1);
    wr(1'b0, 32'h5A00_0020);
    wr(1'b0, 32'h5A00_0000);
    repeat (3) @(negedge clk);
    chk(rd_data == 32'h0, "R7 recovered idle", int'(rd_data), 0);

    done = 1;
    summary();
  end
endmodule